// File: doc/BRIEF.md
# Coprocessor Interface Protocol Monitor

This block is the slave end of a coprocessor register interface. The host processor reaches it through CPU-space read and write cycles. The block decodes the address of each cycle into one of a small set of registers:

- a response register, which the host reads to learn what the coprocessor wants next;
- an instruction-address register, which holds the address of the instruction being executed;
- a command register, which starts a new operation;
- any other register, which falls into a catch-all group.

A command write makes the block busy and publishes a response primitive. When the command asks for it, that primitive carries a PC-transfer request. The block then watches whether the host answers the request by writing the instruction-address register before it touches any other register.

The `conc_mode` input selects how an unanswered request is treated:

- In concurrent-execution mode, an unanswered request is a protocol violation. The violation is fatal and takes priority over any pending instruction exception. The host's acknowledge of the violation aborts the operation in progress and flushes every pending exception. After that acknowledge, the response register reads as a null primitive.
- In peripheral-only mode, an unanswered request is dropped without complaint.

The arithmetic datapath sits outside this block. It tells the block when an operation finishes (`op_done`) and when an instruction exception occurs (`instr_exc`).

Top module: `cpif_monitor`

## Requirements
- R1: A bus cycle reaches the block only when all of these hold: function code is 7, address bits [19:16] are 4'h2, bits [15:13] equal `CP_ID`, and all other address bits above the 5-bit offset are zero. Cycles that fail this decode have no effect; for example, a command write with function code 5 leaves `busy` at 0.
- R2: After reset the block is idle: `busy`=0, `exc_pend`=0, `exc_code`=0, `ia_value`=0, and the response register (offset 0x00) reads 16'h0000.
- R3: A command write (offset 0x0A) sets `busy` from the next cycle. The response then reads {bit15 CA=1, bit14 PC request = command bit 15, bits[13:0] = command bits[13:0]}.
- R4: Every write to the instruction-address register (offset 0x18) loads `ia_value` with the written data, whether or not a PC transfer was requested. Such a write also clears an outstanding PC request, which drops response bit 14.
- R5: In concurrent mode (`conc_mode`=1), any access to the command register or to another non-response register while a PC request is outstanding raises a protocol violation. From the next cycle `exc_pend`=1, `exc_code`=2, and the response reads 16'h1C0D. The violating access is discarded. Command writes are also discarded while the violation awaits acknowledge.
- R6: Reads of the response register never raise a violation, even while a PC request is outstanding.
- R7: In peripheral mode (`conc_mode`=0), an unanswered PC request never raises a violation. The next non-response, non-instruction-address access drops the request and takes effect normally.
- R8: A protocol violation outranks an instruction exception. With both pending, `exc_code`=2 and the response reads 16'h1C0D.
- R9: Acknowledging a protocol violation does the following from the next cycle: clears all pending exceptions, clears `busy` and the PC request, pulses `abort` for one cycle, and makes the response read 16'h0000 (CA=0).
- R10: An instruction exception alone gives `exc_pend`=1, `exc_code`=1 and response 16'h1C30. Its acknowledge clears it and leaves `busy` unchanged.
- R11: `op_done` clears `busy` and any PC request, so the response returns to 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conc_mode | input | 1 | 1 = concurrent execution, 0 = peripheral-only |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_fc | input | 3 | Function code of the cycle |
| bus_addr | input | ADDR_W | Cycle address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | 16 | Read data; the response primitive on a decoded response read, else 0 |
| op_done | input | 1 | Datapath finished the current operation |
| instr_exc | input | 1 | Datapath raises an instruction exception |
| exc_ack | input | 1 | One-cycle exception acknowledge from the host |
| exc_pend | output | 1 | Some exception is pending |
| exc_code | output | 2 | 0 none, 1 instruction exception, 2 protocol violation |
| busy | output | 1 | Operation in progress |
| abort | output | 1 | One-cycle pulse when a violation acknowledge aborts work |
| ia_value | output | DATA_W | Instruction-address latch |

## Verification
The bench builds the block with its defaults: `CP_ID`=1, a 32-bit address and data bus, and the offsets 0x00, 0x0A and 0x18. With these values the response register sits at 0x00022000, and a neighbouring unit ID (0x00024000) gives a near-miss address that must be ignored. A full 32-bit instruction-address write shows that the upper half of the data lands in the latch. Both `conc_mode` settings are run on the same request sequence. This exposes the one place where the two modes differ: a foreign access made while a PC request is outstanding.

// File: rtl/cpif_pkg.sv
// Package: shared types and primitive encodings for the coprocessor
// interface monitor. Assumes a 16-bit response primitive.
package cpif_pkg;

    localparam int RESP_W = 16;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_INSTR = 2'd1,
        EXC_PROTO = 2'd2
    } exc_kind_e;

    // One decoded bus cycle; at most one register flag is set.
    typedef struct packed {
        logic rd;
        logic wr;
        logic resp;
        logic cmd;
        logic ia;
        logic other;
    } cp_acc_t;

    localparam logic [7:0] VEC_PROTO = 8'h0D;
    localparam logic [7:0] VEC_INSTR = 8'h30;
    localparam logic [7:0] EXC_PRIM_HI = 8'h1C;

    // Exception primitive with CA and PC request both clear.
    function automatic logic [RESP_W-1:0] exc_prim(input logic [7:0] vec);
        return {EXC_PRIM_HI, vec};
    endfunction

endpackage

// File: rtl/cpif_decode.sv
// Address decoder: turns one CPU-space bus cycle into a register-select
// record. Assumes ADDR_W > 20 and OFS_W < 13; all unused address bits
// must be zero for a hit.
module cpif_decode
    import cpif_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          OFS_W    = 5,
    parameter logic [2:0]  CP_ID    = 3'd1,
    parameter logic [3:0]  CP_SPACE = 4'h2,
    parameter logic [OFS_W-1:0] OFS_RESP = 5'h00,
    parameter logic [OFS_W-1:0] OFS_CMD  = 5'h0A,
    parameter logic [OFS_W-1:0] OFS_IA   = 5'h18
) (
    input  logic              valid,
    input  logic              we,
    input  logic [2:0]        fc,
    input  logic [ADDR_W-1:0] addr,
    output cp_acc_t           acc
);
    localparam logic [2:0] FC_CPU = 3'd7;

    logic hit;
    logic [OFS_W-1:0] ofs;

    // Decide whether the cycle targets this unit at all.
    always_comb begin
        ofs = addr[OFS_W-1:0];
        hit = valid && (fc == FC_CPU)
              && (addr[ADDR_W-1:20] == '0)
              && (addr[19:16] == CP_SPACE)
              && (addr[15:13] == CP_ID)
              && (addr[12:OFS_W] == '0);
    end

    // Split a hit into the register groups the monitor cares about.
    always_comb begin
        acc.rd    = hit && !we;
        acc.wr    = hit && we;
        acc.resp  = hit && (ofs == OFS_RESP);
        acc.cmd   = hit && (ofs == OFS_CMD);
        acc.ia    = hit && (ofs == OFS_IA);
        acc.other = hit && (ofs != OFS_RESP) && (ofs != OFS_CMD) && (ofs != OFS_IA);
    end

    always_comb begin
        assert ($countones({acc.resp, acc.cmd, acc.ia, acc.other}) <= 1)
            else $error("p_one_reg_r1: decoder selected more than one register");
    end

endmodule

// File: rtl/cpif_pcreq_track.sv
// PC-request tracker: holds the outstanding PC-transfer request and
// decides whether the current access is a protocol violation or an
// accepted command. Assumes flush comes from a violation acknowledge.
module cpif_pcreq_track
    import cpif_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    conc_mode,
    input  cp_acc_t acc,
    input  logic    need_pc,
    input  logic    proto_pend,
    input  logic    flush,
    input  logic    done,
    output logic    pc_req,
    output logic    viol,
    output logic    cmd_accept
);
    logic foreign;

    // Classify the access against the outstanding request.
    always_comb begin
        foreign    = acc.cmd || acc.other;
        viol       = pc_req && conc_mode && foreign && !proto_pend;
        cmd_accept = acc.cmd && acc.wr && !viol && !proto_pend;
    end

    // Track the PC request raised by the last accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_req <= 1'b0;
        end else if (flush) begin
            pc_req <= 1'b0;
        end else if (cmd_accept) begin
            pc_req <= need_pc;
        end else if ((acc.ia && acc.wr) || foreign || done) begin
            pc_req <= 1'b0;
        end
    end

    p_ia_answers_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.ia && acc.wr && !flush) |=> !pc_req)
        else $error("p_ia_answers_r4");

    p_resp_read_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.resp && acc.rd) |-> !viol)
        else $error("p_resp_read_quiet_r6");

endmodule

// File: rtl/cpif_exc_ctrl.sv
// Exception controller: holds pending protocol and instruction
// exceptions, ranks them and handles the acknowledge. Assumes viol is
// only raised while no protocol violation is pending.
module cpif_exc_ctrl
    import cpif_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      viol,
    input  logic      instr_exc,
    input  logic      exc_ack,
    output logic      proto_pend,
    output logic      instr_pend,
    output logic      flush,
    output logic      abort,
    output exc_kind_e exc_kind
);
    // A violation acknowledge flushes everything.
    always_comb flush = exc_ack && proto_pend;

    // Pending protocol violation.
    always_ff @(posedge clk) begin
        if (!rst_n)       proto_pend <= 1'b0;
        else if (viol)    proto_pend <= 1'b1;
        else if (exc_ack) proto_pend <= 1'b0;
    end

    // Pending instruction exception; any acknowledge clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         instr_pend <= 1'b0;
        else if (exc_ack)   instr_pend <= 1'b0;
        else if (instr_exc) instr_pend <= 1'b1;
    end

    // One-cycle abort pulse after a violation acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) abort <= 1'b0;
        else        abort <= flush;
    end

    // Rank pending exceptions, protocol violation first.
    always_comb begin
        if (proto_pend)      exc_kind = EXC_PROTO;
        else if (instr_pend) exc_kind = EXC_INSTR;
        else                 exc_kind = EXC_NONE;
    end

    p_proto_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_pend && instr_pend) |-> (exc_kind == EXC_PROTO))
        else $error("p_proto_first_r8");

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ack && proto_pend) |=> (!proto_pend && !instr_pend && abort))
        else $error("p_ack_clears_r9");

    p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort)
        else $error("p_abort_pulse_r9");

endmodule

// File: rtl/cpif_state.sv
// Operation state: busy flag, command code, instruction-address latch
// and the response primitive view. Assumes DATA_W >= 16.
module cpif_state
    import cpif_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cp_acc_t           acc,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmd_accept,
    input  logic              flush,
    input  logic              done,
    input  logic              pc_req,
    input  logic              proto_pend,
    input  logic              instr_pend,
    output logic              busy,
    output logic [DATA_W-1:0] ia_q,
    output logic [RESP_W-1:0] resp
);
    localparam int CODE_W = RESP_W - 2;

    logic [CODE_W-1:0] code_q;

    // Busy from an accepted command until done or abort.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy <= 1'b0;
        else if (flush)      busy <= 1'b0;
        else if (cmd_accept) busy <= 1'b1;
        else if (done)       busy <= 1'b0;
    end

    // Operation code echoed in the response primitive.
    always_ff @(posedge clk) begin
        if (!rst_n)          code_q <= '0;
        else if (flush)      code_q <= '0;
        else if (cmd_accept) code_q <= wdata[CODE_W-1:0];
    end

    // Instruction-address latch accepts every write.
    always_ff @(posedge clk) begin
        if (!rst_n)                ia_q <= '0;
        else if (acc.ia && acc.wr) ia_q <= wdata;
    end

    // Compose the response primitive from current state.
    always_comb begin
        if (proto_pend)      resp = exc_prim(VEC_PROTO);
        else if (instr_pend) resp = exc_prim(VEC_INSTR);
        else if (busy)       resp = {1'b1, pc_req, code_q};
        else                 resp = '0;
    end

    p_ia_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.ia && acc.wr) |=> (ia_q == $past(wdata)))
        else $error("p_ia_load_r4");

    p_cmd_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && !flush) |=> busy)
        else $error("p_cmd_busy_r3");

    p_flush_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!busy && code_q == '0))
        else $error("p_flush_idle_r9");

endmodule

// File: rtl/cpif_monitor.sv
// Top: coprocessor interface protocol monitor. Decodes host CPU-space
// cycles, tracks PC-transfer requests, flags protocol violations and
// serves the response register. Assumes one bus cycle per clock.
module cpif_monitor
    import cpif_pkg::*;
#(
    parameter int         ADDR_W = 32,
    parameter int         DATA_W = 32,
    parameter int         OFS_W  = 5,
    parameter logic [2:0] CP_ID  = 3'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conc_mode,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [2:0]        bus_fc,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              op_done,
    input  logic              instr_exc,
    input  logic              exc_ack,
    output logic              exc_pend,
    output logic [1:0]        exc_code,
    output logic              busy,
    output logic              abort,
    output logic [DATA_W-1:0] ia_value
);
    localparam int NEED_PC_BIT = RESP_W - 1;

    cp_acc_t           acc;
    logic              pc_req, viol, cmd_accept;
    logic              proto_pend, instr_pend, flush;
    exc_kind_e         exc_kind;
    logic [RESP_W-1:0] resp;

    cpif_decode #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .CP_ID(CP_ID)
    ) u_decode (
        .valid(bus_valid), .we(bus_we), .fc(bus_fc), .addr(bus_addr), .acc(acc)
    );

    cpif_pcreq_track u_track (
        .clk(clk), .rst_n(rst_n), .conc_mode(conc_mode), .acc(acc),
        .need_pc(bus_wdata[NEED_PC_BIT]), .proto_pend(proto_pend),
        .flush(flush), .done(op_done), .pc_req(pc_req), .viol(viol),
        .cmd_accept(cmd_accept)
    );

    cpif_exc_ctrl u_exc (
        .clk(clk), .rst_n(rst_n), .viol(viol), .instr_exc(instr_exc),
        .exc_ack(exc_ack), .proto_pend(proto_pend), .instr_pend(instr_pend),
        .flush(flush), .abort(abort), .exc_kind(exc_kind)
    );

    cpif_state #(.DATA_W(DATA_W)) u_state (
        .clk(clk), .rst_n(rst_n), .acc(acc), .wdata(bus_wdata),
        .cmd_accept(cmd_accept), .flush(flush), .done(op_done),
        .pc_req(pc_req), .proto_pend(proto_pend), .instr_pend(instr_pend),
        .busy(busy), .ia_q(ia_value), .resp(resp)
    );

    // Drive the host-visible outputs.
    always_comb begin
        bus_rdata = (acc.rd && acc.resp) ? resp : '0;
        exc_pend  = proto_pend || instr_pend;
        exc_code  = exc_kind;
    end

    p_periph_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!conc_mode && !proto_pend) |=> !proto_pend)
        else $error("p_periph_silent_r7");

    p_viol_blocks_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_pend && !flush && !op_done) |=> $stable(busy))
        else $error("p_viol_blocks_cmd_r5");

endmodule

// File: tb/cpif_monitor_bench.sv
// Scoreboard bench: driver tasks push expected values, a monitor
// process pops and compares them one time unit after each falling edge.
module cpif_monitor_bench;

    localparam int SEL_RDATA = 0, SEL_BUSY = 1, SEL_PEND = 2,
                   SEL_CODE = 3, SEL_IA = 4, SEL_ABORT = 5;
    localparam logic [4:0] O_RESP = 5'h00, O_CMD = 5'h0A, O_IA = 5'h18, O_OPND = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conc_mode = 1'b1;
    logic        bus_valid = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_fc = 3'd0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        op_done = 1'b0, instr_exc = 1'b0, exc_ack = 1'b0;
    logic        exc_pend, busy, abort;
    logic [1:0]  exc_code;
    logic [31:0] ia_value;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    typedef struct {
        string       req;
        int          sel;
        logic [31:0] exp;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    cpif_monitor u_cpif_monitor (
        .clk(clk), .rst_n(rst_n), .conc_mode(conc_mode),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_fc(bus_fc),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .op_done(op_done), .instr_exc(instr_exc), .exc_ack(exc_ack),
        .exc_pend(exc_pend), .exc_code(exc_code), .busy(busy),
        .abort(abort), .ia_value(ia_value)
    );

    function automatic logic [31:0] cp_addr(input logic [2:0] id, input logic [4:0] ofs);
        return {12'h000, 4'h2, id, 8'h00, ofs};
    endfunction

    function automatic logic [31:0] observe(input int sel);
        case (sel)
            SEL_RDATA: return {16'h0, bus_rdata};
            SEL_BUSY:  return {31'h0, busy};
            SEL_PEND:  return {31'h0, exc_pend};
            SEL_CODE:  return {30'h0, exc_code};
            SEL_IA:    return ia_value;
            default:   return {31'h0, abort};
        endcase
    endfunction

    task automatic push(input string req, input int sel, input logic [31:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        sb.push_back(it);
    endtask

    // Monitor: compare all queued expectations after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic bus_op(input logic we, input logic [2:0] fc, input logic [31:0] a,
                          input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = we; bus_fc = fc; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] ofs, input logic [31:0] d);
        bus_op(1'b1, 3'd7, cp_addr(3'd1, ofs), d);
    endtask

    task automatic read_resp(input string req, input logic [15:0] exp);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_fc = 3'd7; bus_addr = cp_addr(3'd1, O_RESP);
        push(req, SEL_RDATA, {16'h0, exp});
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    endtask
    task automatic pulse_iexc();
        @(negedge clk); instr_exc = 1'b1; @(negedge clk); instr_exc = 1'b0;
    endtask
    task automatic pulse_ack();
        @(negedge clk); exc_ack = 1'b1; @(negedge clk); exc_ack = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Driver: stimulus and expectations.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push("R2 busy", SEL_BUSY, 0);
        push("R2 pend", SEL_PEND, 0);
        push("R2 code", SEL_CODE, 0);
        push("R2 ia", SEL_IA, 0);
        read_resp("R2 null response", 16'h0000);

        // R1: decode misses have no effect
        bus_op(1'b1, 3'd5, cp_addr(3'd1, O_CMD), 32'h0000_0123);
        push("R1 wrong fc", SEL_BUSY, 0);
        bus_op(1'b1, 3'd7, cp_addr(3'd2, O_CMD), 32'h0000_0123);
        push("R1 wrong id", SEL_BUSY, 0);
        bus_op(1'b1, 3'd7, cp_addr(3'd1, O_IA) | 32'h0010_0000, 32'h5555_5555);
        push("R1 upper bits", SEL_IA, 0);

        // R3 and R11
        wr(O_CMD, 32'h0000_0123);
        push("R3 busy", SEL_BUSY, 1);
        read_resp("R3 response", 16'h8123);
        pulse_done();
        push("R11 busy cleared", SEL_BUSY, 0);
        read_resp("R11 null", 16'h0000);

        // R4 unsolicited write
        wr(O_IA, 32'hDEAD_BEEF);
        push("R4 unsolicited", SEL_IA, 32'hDEAD_BEEF);

        // R6 then R4 answering the request
        wr(O_CMD, 32'h0000_8045);
        read_resp("R3 pc request", 16'hC045);
        push("R6 no viol", SEL_PEND, 0);
        wr(O_IA, 32'h0000_1000);
        push("R4 answered ia", SEL_IA, 32'h0000_1000);
        read_resp("R4 pc bit dropped", 16'h8045);
        wr(O_OPND, 32'h0);
        push("R4 answered no viol", SEL_PEND, 0);
        pulse_done();

        // R5, R8, R9
        wr(O_CMD, 32'h0000_8077);
        wr(O_CMD, 32'h0000_0011);
        push("R5 pend", SEL_PEND, 1);
        push("R5 code", SEL_CODE, 2);
        read_resp("R5 proto prim", 16'h1C0D);
        pulse_iexc();
        push("R8 code", SEL_CODE, 2);
        read_resp("R8 response", 16'h1C0D);
        wr(O_IA, 32'hCAFE_0001);
        push("R4 during violation", SEL_IA, 32'hCAFE_0001);
        pulse_ack();
        push("R9 abort", SEL_ABORT, 1);
        push("R9 pend", SEL_PEND, 0);
        push("R9 busy", SEL_BUSY, 0);
        read_resp("R9 null after ack", 16'h0000);
        push("R9 abort one cycle", SEL_ABORT, 0);

        // R10
        wr(O_CMD, 32'h0000_0005);
        pulse_iexc();
        push("R10 pend", SEL_PEND, 1);
        push("R10 code", SEL_CODE, 1);
        read_resp("R10 response", 16'h1C30);
        pulse_ack();
        push("R10 pend cleared", SEL_PEND, 0);
        push("R10 busy kept", SEL_BUSY, 1);
        push("R10 no abort", SEL_ABORT, 0);
        pulse_done();

        // R7 peripheral mode
        conc_mode = 1'b0;
        wr(O_CMD, 32'h0000_8099);
        read_resp("R7 request shown", 16'hC099);
        wr(O_OPND, 32'h0);
        push("R7 no viol", SEL_PEND, 0);
        read_resp("R7 request dropped", 16'h8099);
        wr(O_CMD, 32'h0000_80AA);
        wr(O_CMD, 32'h0000_0042);
        push("R7 command took effect pend", SEL_PEND, 0);
        read_resp("R7 command took effect", 16'h8042);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule